// File: doc/BRIEF.md
# AUX-to-I2C Transaction Bridge Sequencer

This block accepts decoded auxiliary-channel requests, one at a time, and turns each into an ordered series of byte-level I2C master operations for a separate bit-level engine. A request carries a command (I2C write, I2C read or write-status), a device address, a middle-of-transaction flag (MOT) and, optionally, a length with write data. The block keeps the bus state (idle, open for writing, open for reading) and the last device address between requests. This lets it choose between START, repeated START, a bare data continuation and a closing STOP.

Each request ends with one response carrying an ACK/NACK code and a byte count. A write that a target NACKs part-way is cut short, and its outcome is kept for a later write-status request. Read bytes are passed out one by one as they arrive.

The sequencer has six states. IDLE waits for a request. START issues START or repeated START. ADDR writes the address byte. DATA moves one data byte per operation. STOP closes the bus. RESP presents the response for one cycle.

The transitions are as follows. IDLE goes to START for a framed request, to DATA for a continuation, to STOP for a close, and to RESP for a write-status request that needs no bus activity. START goes to ADDR. ADDR goes to DATA, to RESP (address-only request) or to STOP (address NACK). DATA loops on itself until the last byte or a write NACK, then goes to RESP if MOT=1 or to STOP if MOT=0. STOP goes to RESP, and RESP goes to IDLE.

Top module: `aux_i2c_sequencer`

## Requirements
- R1: After reset, `busy`, `op_valid`, `rsp_valid` and `rd_valid` are low, and the bus is tracked as idle, so the first framed request begins with START (op_kind 0) rather than repeated START (op_kind 1).
- R2: An address-only write or read (req_cmd 0 or 1, req_has_len=0) with MOT=1 issues START, or repeated START if the bus is open. It then issues a WRITE (op_kind 2) of the address byte {addr, rw}, with rw=1 for read. No data and no STOP follow. The response is ACK (code 0) with count 0, and the bus stays open in that direction.
- R3: An address-only request with MOT=0 issues a single STOP (op_kind 4) whatever the bus state. It answers ACK with count 0 and leaves the bus idle.
- R4: A write with a length field N issues START or repeated START and the address byte. It then issues N+1 data WRITEs carrying `wr_byte` for `wr_idx` = 0..N, and answers ACK with count N+1.
- R5: A write or read with a length, arriving while the bus is open in the same direction to the same address, skips START and the address byte and issues only the data operations.
- R6: A write or read with a length and MOT=0 appends a STOP after its last data operation and leaves the bus idle. With MOT=1 no STOP is issued and the bus stays open.
- R7: A read with length N issues N+1 READs (op_kind 3) and pulses `rd_valid` with `op_rdata` after each one. `op_mack` is 1 (master ACK) on every READ except the last READ of a MOT=0 request, where it is 0. The response is ACK with count N+1.
- R8: A framed request to a different address or direction while the bus is open starts with repeated START, never with STOP.
- R9: If a data byte of a write is NACKed (`op_nack`=1), no further data is written. The response is NACK (code 1) with the count of bytes ACKed before it. With MOT=1 the bus stays open; with MOT=0 a STOP follows.
- R10: A write-status request (req_cmd 2) with MOT=1 issues no operation. It answers with the code and count of the most recent write data phase (ACK and N+1 if it completed, NACK and the accepted count if it was cut short; ACK and 0 before any write).
- R11: A write-status request with MOT=0 issues one STOP if the bus is open and none if it is idle. It answers like R10 and leaves the bus idle.
- R12: A NACKed address byte is followed by a STOP. The response is NACK with count 0 and the bus is left idle.
- R13: Each accepted request yields exactly one single-cycle `rsp_valid` pulse. `busy` is high from the cycle after acceptance until the response. Each operation holds its kind and data until `op_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_cmd | input | 2 | 0 write, 1 read, 2 write-status |
| req_addr | input | DATA_W-1 | 7-bit device address |
| req_mot | input | 1 | Middle-of-transaction flag |
| req_has_len | input | 1 | Request carries a length (data phase) |
| req_len | input | LEN_W | Byte count minus one |
| busy | output | 1 | A request is being processed |
| wr_idx | output | LEN_W | Index of the write byte wanted |
| wr_byte | input | DATA_W | Write data byte at `wr_idx` |
| op_valid | output | 1 | Byte-level operation requested |
| op_kind | output | 3 | 0 START, 1 RSTART, 2 WRITE, 3 READ, 4 STOP |
| op_wdata | output | DATA_W | Byte to write (address or data) |
| op_mack | output | 1 | Master ACK (1) or NACK (0) after a READ |
| op_done | input | 1 | Engine finished the current operation |
| op_nack | input | 1 | Target NACKed the written byte |
| op_rdata | input | DATA_W | Byte read by the engine |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | DATA_W | Read byte |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | 0 ACK, 1 NACK |
| rsp_count | output | LEN_W+1 | Bytes transferred or reported |

## Verification
The assertions assume two things about the inputs. First, `op_done` arrives only while `op_valid` is high, and only once per operation. Second, a new request is presented only while `busy` is low. The bench's engine model meets both. It waits for `op_valid` at a falling edge and returns a one-cycle `op_done` with `op_nack` and `op_rdata`, and it never answers two operations back to back without dropping `op_done`. The request driver raises `req_valid` for exactly one cycle, only after the previous response has come and gone. Target NACKs are produced only by the engine model, at a configured byte index or on the address byte.

// File: rtl/aux_i2c_pkg.sv
package aux_i2c_pkg;

    typedef enum logic [1:0] {
        CMD_WRITE = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WSTAT = 2'd2
    } cmd_e;

    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_RSTART = 3'd1,
        OP_WRITE  = 3'd2,
        OP_READ   = 3'd3,
        OP_STOP   = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        BUS_IDLE    = 2'd0,
        BUS_WR_OPEN = 2'd1,
        BUS_RD_OPEN = 2'd2
    } bus_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_ADDR  = 3'd2,
        S_DATA  = 3'd3,
        S_STOP  = 3'd4,
        S_RESP  = 3'd5
    } seq_e;

    localparam logic [1:0] RSP_ACK  = 2'd0;
    localparam logic [1:0] RSP_NACK = 2'd1;

endpackage

// File: rtl/aux_i2c_bus_tracker.sv
module aux_i2c_bus_tracker
    import aux_i2c_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_en,
    input  logic              open_rd,
    input  logic [ADDR_W-1:0] open_addr,
    input  logic              close_en,
    input  logic              chk_rd,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              bus_open,
    output logic              path_match
);

    bus_e              bus_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q  <= BUS_IDLE;
            addr_q <= '0;
        end else if (close_en) begin
            bus_q  <= BUS_IDLE;
        end else if (open_en) begin
            bus_q  <= open_rd ? BUS_RD_OPEN : BUS_WR_OPEN;
            addr_q <= open_addr;
        end
    end

    assign bus_open   = (bus_q != BUS_IDLE);
    assign path_match = (chk_rd ? (bus_q == BUS_RD_OPEN) : (bus_q == BUS_WR_OPEN))
                        && (addr_q == chk_addr);

    // The sequencer never opens and closes the bus in the same cycle.
    assert_single_update_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_en && close_en));

endmodule

// File: rtl/aux_i2c_wr_status.sv
module aux_i2c_wr_status #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_en,
    input  logic             rec_nack,
    input  logic [CNT_W-1:0] rec_cnt,
    output logic             st_nack,
    output logic [CNT_W-1:0] st_cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_nack <= 1'b0;
            st_cnt  <= '0;
        end else if (rec_en) begin
            st_nack <= rec_nack;
            st_cnt  <= rec_cnt;
        end
    end

endmodule

// File: rtl/aux_i2c_seq_fsm.sv
module aux_i2c_seq_fsm
    import aux_i2c_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_cmd,
    input  logic [DATA_W-2:0]   req_addr,
    input  logic                req_mot,
    input  logic                req_has_len,
    input  logic [LEN_W-1:0]    req_len,
    output logic                busy,
    output logic [LEN_W-1:0]    wr_idx,
    input  logic [DATA_W-1:0]   wr_byte,
    output logic                op_valid,
    output logic [2:0]          op_kind,
    output logic [DATA_W-1:0]   op_wdata,
    output logic                op_mack,
    input  logic                op_done,
    input  logic                op_nack,
    input  logic [DATA_W-1:0]   op_rdata,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rsp_valid,
    output logic [1:0]          rsp_code,
    output logic [LEN_W:0]      rsp_count,
    input  logic                bus_open,
    input  logic                path_match,
    output logic                chk_rd,
    output logic [DATA_W-2:0]   chk_addr,
    output logic                open_en,
    output logic                open_rd,
    output logic [DATA_W-2:0]   open_addr,
    output logic                close_en,
    input  logic                st_nack,
    input  logic [LEN_W:0]      st_cnt,
    output logic                rec_en,
    output logic                rec_nack,
    output logic [LEN_W:0]      rec_cnt
);

    localparam int ADDR_W = DATA_W - 1;
    localparam int CNT_W  = LEN_W + 1;
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
    localparam logic [LEN_W-1:0] ONE_I = LEN_W'(1);

    seq_e              state, state_n;
    logic              q_rd, q_mot, q_hl, use_rs;
    logic [ADDR_W-1:0] q_addr;
    logic [LEN_W-1:0]  q_len, idx;
    logic [1:0]        code_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              rdv_q;
    logic [DATA_W-1:0] rdd_q;
    logic              accept, last_byte, wr_fail;

    assign accept    = (state == S_IDLE) && req_valid;
    assign last_byte = (idx == q_len);
    assign wr_fail   = !q_rd && op_nack;

    // request lookup into the bus tracker
    assign chk_rd   = (req_cmd == CMD_READ);
    assign chk_addr = req_addr;

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_cmd[1])
                        state_n = (!req_mot && bus_open) ? S_STOP : S_RESP;
                    else if (!req_has_len && !req_mot)
                        state_n = S_STOP;
                    else if (req_has_len && path_match)
                        state_n = S_DATA;
                    else
                        state_n = S_START;
                end
            end
            S_START: if (op_done) state_n = S_ADDR;
            S_ADDR: begin
                if (op_done) begin
                    if (op_nack)   state_n = S_STOP;
                    else if (q_hl) state_n = S_DATA;
                    else           state_n = S_RESP;
                end
            end
            S_DATA: begin
                if (op_done && (wr_fail || last_byte))
                    state_n = q_mot ? S_RESP : S_STOP;
            end
            S_STOP: if (op_done) state_n = S_RESP;
            S_RESP: state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // state register and request context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            q_rd   <= 1'b0;
            q_mot  <= 1'b0;
            q_hl   <= 1'b0;
            use_rs <= 1'b0;
            q_addr <= '0;
            q_len  <= '0;
            idx    <= '0;
            code_q <= RSP_ACK;
            cnt_q  <= '0;
            rdv_q  <= 1'b0;
            rdd_q  <= '0;
        end else begin
            state <= state_n;
            rdv_q <= 1'b0;
            if (accept) begin
                q_rd   <= (req_cmd == CMD_READ);
                q_mot  <= req_mot;
                q_hl   <= req_has_len;
                q_addr <= req_addr;
                q_len  <= req_len;
                use_rs <= bus_open;
                idx    <= '0;
                if (req_cmd[1]) begin
                    code_q <= st_nack ? RSP_NACK : RSP_ACK;
                    cnt_q  <= st_cnt;
                end else begin
                    code_q <= RSP_ACK;
                    cnt_q  <= '0;
                end
            end
            if (state == S_ADDR && op_done && op_nack)
                code_q <= RSP_NACK;
            if (state == S_DATA && op_done) begin
                if (q_rd) begin
                    rdv_q <= 1'b1;
                    rdd_q <= op_rdata;
                end
                if (wr_fail) begin
                    code_q <= RSP_NACK;
                    cnt_q  <= {1'b0, idx};
                end else if (last_byte) begin
                    cnt_q  <= {1'b0, q_len} + ONE_C;
                end else begin
                    idx    <= idx + ONE_I;
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state != S_IDLE);
        op_valid  = 1'b0;
        op_kind   = OP_STOP;
        op_wdata  = '0;
        op_mack   = 1'b1;
        rsp_valid = (state == S_RESP);
        unique case (state)
            S_START: begin
                op_valid = 1'b1;
                op_kind  = use_rs ? OP_RSTART : OP_START;
            end
            S_ADDR: begin
                op_valid = 1'b1;
                op_kind  = OP_WRITE;
                op_wdata = {q_addr, q_rd};
            end
            S_DATA: begin
                op_valid = 1'b1;
                op_kind  = q_rd ? OP_READ : OP_WRITE;
                op_wdata = q_rd ? '0 : wr_byte;
                op_mack  = !(q_rd && last_byte && !q_mot);
            end
            S_STOP: begin
                op_valid = 1'b1;
                op_kind  = OP_STOP;
            end
            default: ;
        endcase
    end

    assign wr_idx    = idx;
    assign rd_valid  = rdv_q;
    assign rd_data   = rdd_q;
    assign rsp_code  = code_q;
    assign rsp_count = cnt_q;

    // tracker and status updates
    assign open_en   = (state == S_ADDR) && op_done && !op_nack;
    assign open_rd   = q_rd;
    assign open_addr = q_addr;
    assign close_en  = (state == S_STOP) && op_done;
    assign rec_en    = (state == S_DATA) && op_done && !q_rd && (op_nack || last_byte);
    assign rec_nack  = op_nack;
    assign rec_cnt   = op_nack ? {1'b0, idx} : ({1'b0, q_len} + ONE_C);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !op_valid && !rsp_valid);

    assert_op_held_R13: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_done |=> op_valid && $stable(op_kind) && $stable(op_wdata));

    assert_rsp_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_done_needs_op_R13: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> op_valid);

    assert_rd_follows_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(op_done && op_kind == OP_READ));

    assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_count <= ({1'b0, {LEN_W{1'b1}}} + ONE_C));

endmodule

// File: rtl/aux_i2c_sequencer.sv
module aux_i2c_sequencer
    import aux_i2c_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_cmd,
    input  logic [DATA_W-2:0]   req_addr,
    input  logic                req_mot,
    input  logic                req_has_len,
    input  logic [LEN_W-1:0]    req_len,
    output logic                busy,
    output logic [LEN_W-1:0]    wr_idx,
    input  logic [DATA_W-1:0]   wr_byte,
    output logic                op_valid,
    output logic [2:0]          op_kind,
    output logic [DATA_W-1:0]   op_wdata,
    output logic                op_mack,
    input  logic                op_done,
    input  logic                op_nack,
    input  logic [DATA_W-1:0]   op_rdata,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rsp_valid,
    output logic [1:0]          rsp_code,
    output logic [LEN_W:0]      rsp_count
);

    localparam int ADDR_W = DATA_W - 1;
    localparam int CNT_W  = LEN_W + 1;

    logic              bus_open, path_match, chk_rd;
    logic [ADDR_W-1:0] chk_addr, open_addr;
    logic              open_en, open_rd, close_en;
    logic              st_nack, rec_en, rec_nack;
    logic [CNT_W-1:0]  st_cnt, rec_cnt;

    aux_i2c_bus_tracker #(.ADDR_W(ADDR_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_en    (open_en),
        .open_rd    (open_rd),
        .open_addr  (open_addr),
        .close_en   (close_en),
        .chk_rd     (chk_rd),
        .chk_addr   (chk_addr),
        .bus_open   (bus_open),
        .path_match (path_match)
    );

    aux_i2c_wr_status #(.CNT_W(CNT_W)) u_wst (
        .clk      (clk),
        .rst_n    (rst_n),
        .rec_en   (rec_en),
        .rec_nack (rec_nack),
        .rec_cnt  (rec_cnt),
        .st_nack  (st_nack),
        .st_cnt   (st_cnt)
    );

    aux_i2c_seq_fsm #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_cmd     (req_cmd),
        .req_addr    (req_addr),
        .req_mot     (req_mot),
        .req_has_len (req_has_len),
        .req_len     (req_len),
        .busy        (busy),
        .wr_idx      (wr_idx),
        .wr_byte     (wr_byte),
        .op_valid    (op_valid),
        .op_kind     (op_kind),
        .op_wdata    (op_wdata),
        .op_mack     (op_mack),
        .op_done     (op_done),
        .op_nack     (op_nack),
        .op_rdata    (op_rdata),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .rsp_valid   (rsp_valid),
        .rsp_code    (rsp_code),
        .rsp_count   (rsp_count),
        .bus_open    (bus_open),
        .path_match  (path_match),
        .chk_rd      (chk_rd),
        .chk_addr    (chk_addr),
        .open_en     (open_en),
        .open_rd     (open_rd),
        .open_addr   (open_addr),
        .close_en    (close_en),
        .st_nack     (st_nack),
        .st_cnt      (st_cnt),
        .rec_en      (rec_en),
        .rec_nack    (rec_nack),
        .rec_cnt     (rec_cnt)
    );

endmodule

// File: tb/sim_aux_i2c_sequencer.sv
module sim_aux_i2c_sequencer;

    logic       clk, rst_n;
    logic       req_valid, req_mot, req_has_len;
    logic [1:0] req_cmd;
    logic [6:0] req_addr;
    logic [3:0] req_len;
    logic       busy, op_valid, op_mack, rd_valid, rsp_valid;
    logic [3:0] wr_idx;
    logic [7:0] wr_byte, op_wdata, op_rdata, rd_data;
    logic [2:0] op_kind;
    logic       op_done, op_nack;
    logic [1:0] rsp_code;
    logic [4:0] rsp_count;

    int checks = 0;
    int errors = 0;

    // engine model state
    int  log_w[64];
    int  log_n;
    int  wr_ctr, rd_ctr;
    int  sl_nack_at;
    bit  sl_nack_addr;
    bit  addr_phase;
    int  rd_got[32];
    int  rd_n;
    int  rsp_pulses;

    // bench model of the bus and stored write outcome
    int  mb = 0;
    int  ma = 0;
    int  mws_n = 0;
    int  mws_c = 0;
    int  exp_w[64];
    int  exp_n;

    aux_i2c_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_mot(req_mot), .req_has_len(req_has_len),
        .req_len(req_len), .busy(busy), .wr_idx(wr_idx), .wr_byte(wr_byte),
        .op_valid(op_valid), .op_kind(op_kind), .op_wdata(op_wdata),
        .op_mack(op_mack), .op_done(op_done), .op_nack(op_nack),
        .op_rdata(op_rdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_count(rsp_count)
    );

    assign wr_byte = 8'h5A ^ {wr_idx, wr_idx};

    function automatic int wb(int i);
        logic [3:0] k;
        k = i[3:0];
        return int'(8'h5A ^ {k, k});
    endfunction

    initial begin
        clk = 1'b0;
        forever #10 clk = ~clk;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // byte-level I2C engine and target model
    initial begin
        op_done = 1'b0; op_nack = 1'b0; op_rdata = '0; addr_phase = 1'b0;
        forever begin
            @(negedge clk);
            if (op_done) begin
                op_done = 1'b0;
            end else if (op_valid) begin
                if (log_n < 64) log_w[log_n] = {op_kind, op_mack, op_wdata};
                log_n++;
                op_nack = 1'b0;
                case (op_kind)
                    3'd0, 3'd1: addr_phase = 1'b1;
                    3'd2: begin
                        if (addr_phase) begin
                            op_nack    = sl_nack_addr;
                            addr_phase = 1'b0;
                        end else begin
                            op_nack = (wr_ctr == sl_nack_at);
                            wr_ctr++;
                        end
                    end
                    3'd3: begin
                        op_rdata = 8'h30 + 8'(rd_ctr);
                        rd_ctr++;
                    end
                    default: addr_phase = 1'b0;
                endcase
                op_done = 1'b1;
            end
        end
    end

    // output monitors
    initial begin
        forever begin
            @(negedge clk);
            if (rd_valid) begin
                if (rd_n < 32) rd_got[rd_n] = int'(rd_data);
                rd_n++;
            end
            if (rsp_valid) rsp_pulses++;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     tag, what, act, act, exp, exp);
        end
    endtask

    task automatic push(input int k, input int d, input int m);
        exp_w[exp_n] = (k << 9) | (m << 8) | d;
        exp_n++;
    endtask

    task automatic run_req(input int cmd, input int addr, input int mot, input int hl,
                           input int len, input bit na, input int nat);
        int    ecode, ecnt, dir, nacked, mis;
        bit    cont, abort;
        string tg;
        exp_n = 0; ecode = 0; ecnt = 0; abort = 0; tg = "R4";
        dir = (cmd == 1) ? 1 : 0;
        if (cmd == 2) begin
            tg = mot ? "R10" : "R11";
            if (!mot && mb != 0) begin push(4, 0, 1); mb = 0; end
            ecode = mws_n; ecnt = mws_c;
        end else if (!hl && !mot) begin
            tg = "R3";
            push(4, 0, 1); mb = 0;
        end else begin
            cont = hl && (mb == dir + 1) && (addr == ma);
            if (!hl) tg = "R2";
            else if (cont) tg = "R5";
            else if (mb != 0) tg = "R8";
            else if (dir) tg = "R7";
            else if (!mot) tg = "R6";
            if (nat >= 0) tg = "R9";
            if (na) tg = "R12";
            if (!cont) begin
                push((mb != 0) ? 1 : 0, 0, 1);
                push(2, addr * 2 + dir, 1);
                if (na) begin
                    push(4, 0, 1); mb = 0; ecode = 1; abort = 1;
                end else begin
                    mb = dir + 1; ma = addr;
                end
            end
            if (!abort && hl) begin
                nacked = 0; ecnt = len + 1;
                for (int i = 0; i <= len; i++) begin
                    if (!dir) begin
                        push(2, wb(i), 1);
                        if (i == nat) begin nacked = 1; ecnt = i; break; end
                    end else begin
                        push(3, 0, (i == len && !mot) ? 0 : 1);
                    end
                end
                if (!dir) begin mws_n = nacked; mws_c = ecnt; ecode = nacked; end
                if (!mot) begin push(4, 0, 1); mb = 0; end
            end
        end

        @(negedge clk);
        log_n = 0; rd_n = 0; wr_ctr = 0; rd_ctr = 0; rsp_pulses = 0;
        sl_nack_addr = na; sl_nack_at = nat;
        req_cmd = 2'(cmd); req_addr = 7'(addr); req_mot = mot[0];
        req_has_len = hl[0]; req_len = 4'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R13", "busy after accept", int'(busy), 1);
        while (!rsp_valid) @(negedge clk);
        check(int'(rsp_code) == ecode, tg, "response code", int'(rsp_code), ecode);
        check(int'(rsp_count) == ecnt, tg, "response count", int'(rsp_count), ecnt);
        @(negedge clk);
        check(!rsp_valid && rsp_pulses == 1, "R13", "single response pulse",
              rsp_pulses, 1);
        check(log_n == exp_n, tg, "operation count", log_n, exp_n);
        mis = -1;
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (mis < 0 && log_w[i] != exp_w[i]) mis = i;
        if (mis >= 0)
            check(1'b0, tg, "operation word {kind,mack,data}", log_w[mis], exp_w[mis]);
        else
            check(1'b1, tg, "operation words", 0, 0);
        if (dir == 1 && hl && !na) begin
            check(rd_n == len + 1, "R7", "read strobes", rd_n, len + 1);
            for (int i = 0; i < rd_n && i < 32; i++)
                check(rd_got[i] == 8'h30 + i, "R7", "read byte", rd_got[i], 8'h30 + i);
        end
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_addr = '0; req_mot = 1'b0;
        req_has_len = 1'b0; req_len = '0; log_n = 0; rd_n = 0; rsp_pulses = 0;
        wr_ctr = 0; rd_ctr = 0; sl_nack_at = -1; sl_nack_addr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !op_valid && !rsp_valid && !rd_valid, "R1", "idle after reset",
              int'({busy, op_valid, rsp_valid, rd_valid}), 0);

        // first framed write must use START (R1), then continuation (R5)
        run_req(0, 7'h2A, 1, 1, 1, 1'b0, -1);
        run_req(0, 7'h2A, 1, 1, 2, 1'b0, -1);
        run_req(1, 7'h2A, 1, 1, 1, 1'b0, -1);   // direction change: R8
        run_req(1, 7'h2A, 0, 1, 3, 1'b0, -1);   // R5 read continuation, R7 last NACK, R6 STOP

        // near-exhaustive sweep over command, MOT, length presence and size
        for (int a = 0; a < 2; a++)
            for (int c = 0; c < 3; c++)
                for (int m = 0; m < 2; m++)
                    for (int h = 0; h < 2; h++)
                        for (int li = 0; li < 3; li++)
                            run_req(c, (a == 0) ? 7'h2A : 7'h51, m, h,
                                    (li == 0) ? 0 : ((li == 1) ? 2 : 15), 1'b0, -1);

        // partial write acknowledgement at each position, then status (R9, R10, R11)
        for (int k = 0; k < 4; k++) begin
            run_req(0, 7'h13, k % 2, 1, 3, 1'b0, k);
            run_req(2, 7'h13, 1, 0, 0, 1'b0, -1);
            run_req(2, 7'h13, 0, 0, 0, 1'b0, -1);
        end
        // status close while idle issues nothing (R11)
        run_req(2, 7'h13, 0, 0, 0, 1'b0, -1);
        // address NACK on framed and address-only requests (R12)
        run_req(1, 7'h44, 1, 1, 2, 1'b1, -1);
        run_req(0, 7'h44, 1, 0, 0, 1'b0, -1);
        run_req(0, 7'h45, 1, 0, 0, 1'b1, -1);
        run_req(0, 7'h45, 1, 1, 0, 1'b0, -1);
        // abort from an open bus (R3)
        run_req(1, 7'h45, 0, 0, 0, 1'b0, -1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule